// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block commits the architectural side effects of taking a trap on a core that has machine, supervisor and virtualized-supervisor levels. When a trap is presented for one cycle, it picks where the trap is handled: debug redirection, entry into debug mode, virtual-supervisor, hypervisor-supervisor or machine. It then registers the new program counter, the cause, exception PC and trap value for the selected level, the saved status fields, the new privilege and the virtualization flag.

Delegation uses separate masks for interrupts and for exceptions. Interrupts use the machine and hypervisor interrupt delegation registers. Exceptions use the machine exception delegation register and its AND with the hypervisor exception delegation register. A trap vector base with bit 0 set dispatches interrupts to the base plus four times the cause code.

The surrounding CSR file supplies the current privilege, virtualization flag, debug-mode flag and interrupt enables. It takes the registered results back from this block. Every output holds its value until the next trap.

Top module: `trap_entry_unit`

## Requirements
- R1: After synchronous reset, new_priv is 3 (machine), new_virt, debug_mode and redirect_valid are 0, and every cause, EPC and trap value output is 0.
- R2: With cur_debug set, a breakpoint (exception, code 3) redirects to DBG_ROM_ENTRY and any other trap redirects to DBG_EXC_VEC. handler reads 4, debug_mode stays 1, privilege and virtualization keep their current values, and no cause, EPC or trap value register changes.
- R3: Outside debug mode, a breakpoint taken while the enable matching the current privilege is set (ebk_en_m, ebk_en_s or ebk_en_u) enters debug mode. handler reads 3, dbg_cause becomes 1, dbg_prv becomes the old privilege, dbg_pc becomes trap_epc, new_priv becomes 3 and the PC becomes DBG_ROM_ENTRY.
- R4: A trap goes to virtual-supervisor (handler 2, new_priv 1, new_virt 1) when cur_virt is 1, the privilege is 0 or 1, and the selected bit is set. For interrupts that bit is the code's bit of hideleg; for exceptions it is the code's bit of medeleg AND hedeleg.
- R5: Otherwise, with privilege 0 or 1, a set code bit in mideleg (interrupts) or medeleg (exceptions) sends the trap to hypervisor-supervisor: handler 1, new_priv 1, new_virt 0.
- R6: Machine handling (handler 0, new_priv 3, new_virt 0) is used whenever no delegation applies, including when the privilege is 3 or when the cause code is XLEN or above.
- R7: For handlers 0, 1 and 2, the PC is the selected vector base with bit 0 cleared, plus 4 times the code when base bit 0 is set and the trap is an interrupt.
- R8: A stored cause has the interrupt flag at bit XLEN-1 and the code in the low bits. At the virtual-supervisor level an interrupt cause is stored as that value minus one, while exceptions are stored unchanged.
- R9: Supervisor-level entry copies the enable in use (cur_sie for hypervisor-supervisor, cur_vsie for virtual-supervisor) into the previous-enable bit, stores old privilege bit 0 as the previous privilege, and clears the enable of that level.
- R10: Hypervisor-supervisor entry stores cur_virt in h_spv and trap_gva in h_gva, and updates h_spvp (old privilege bit 0) only when cur_virt was 1.
- R11: Machine entry stores cur_mie in m_pie, the 2-bit old privilege in m_pp, cur_virt in m_pv and trap_gva in m_gva, and clears m_ie.
- R12: All updates commit at the clock edge that samples trap_valid. redirect_valid is high for exactly that following cycle, and outputs hold while trap_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | One-cycle trap strobe |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Cause code |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_tval | input | XLEN | Trap value |
| trap_gva | input | 1 | Trap value is a guest virtual address |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_virt | input | 1 | Currently virtualized |
| cur_debug | input | 1 | Currently in debug mode |
| cur_mie | input | 1 | Machine interrupt enable |
| cur_sie | input | 1 | Supervisor interrupt enable |
| cur_vsie | input | 1 | Virtual-supervisor interrupt enable |
| ebk_en_m | input | 1 | Breakpoint enters debug mode from machine |
| ebk_en_s | input | 1 | Breakpoint enters debug mode from supervisor |
| ebk_en_u | input | 1 | Breakpoint enters debug mode from user |
| medeleg | input | XLEN | Machine exception delegation |
| mideleg | input | XLEN | Machine interrupt delegation |
| hedeleg | input | XLEN | Hypervisor exception delegation |
| hideleg | input | XLEN | Hypervisor interrupt delegation |
| mtvec | input | XLEN | Machine vector base, bit 0 = vectored |
| stvec | input | XLEN | Supervisor vector base, bit 0 = vectored |
| vstvec | input | XLEN | Virtual-supervisor vector base, bit 0 = vectored |
| redirect_valid | output | 1 | Outputs were updated at the last edge |
| redirect_pc | output | XLEN | New program counter |
| handler | output | 3 | 0 machine, 1 hyp-supervisor, 2 virtual-supervisor, 3 debug entry, 4 debug redirect |
| new_priv | output | 2 | Privilege after the trap |
| new_virt | output | 1 | Virtualization after the trap |
| debug_mode | output | 1 | Debug mode after the trap |
| m_cause | output | XLEN | Machine cause |
| m_epc | output | XLEN | Machine exception PC |
| m_tval | output | XLEN | Machine trap value |
| m_ie | output | 1 | Machine enable as written |
| m_pie | output | 1 | Machine previous enable |
| m_pp | output | 2 | Machine previous privilege |
| m_pv | output | 1 | Machine previous virtualization |
| m_gva | output | 1 | Machine guest-address flag |
| s_cause | output | XLEN | Hyp-supervisor cause |
| s_epc | output | XLEN | Hyp-supervisor exception PC |
| s_tval | output | XLEN | Hyp-supervisor trap value |
| s_ie | output | 1 | Supervisor enable as written |
| s_pie | output | 1 | Supervisor previous enable |
| s_pp | output | 1 | Supervisor previous privilege |
| h_spv | output | 1 | Hypervisor previous virtualization |
| h_spvp | output | 1 | Hypervisor previous virtual privilege |
| h_gva | output | 1 | Hypervisor guest-address flag |
| vs_cause | output | XLEN | Virtual-supervisor cause |
| vs_epc | output | XLEN | Virtual-supervisor exception PC |
| vs_tval | output | XLEN | Virtual-supervisor trap value |
| vs_ie | output | 1 | Virtual-supervisor enable as written |
| vs_pie | output | 1 | Virtual-supervisor previous enable |
| vs_pp | output | 1 | Virtual-supervisor previous privilege |
| dbg_cause | output | 3 | Debug entry cause |
| dbg_prv | output | 2 | Privilege at debug entry |
| dbg_pc | output | XLEN | PC saved at debug entry |

## Verification
A breakpoint can satisfy two rules in the same cycle. Debug-mode redirection applies because cur_debug is set, and debug entry also applies because the enable for the current privilege is set. The bench raises cur_debug together with ebk_en_m at machine privilege and traps with code 3. It judges the outcome by handler 4, the PC equal to the ROM entry, and dbg_pc keeping its earlier value. Delegation priority is provoked the same way, with one code set in both the virtual and the hypervisor masks, and the trap is expected at the virtual-supervisor level.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef enum logic [2:0] {
    HND_M         = 3'd0,
    HND_HS        = 3'd1,
    HND_VS        = 3'd2,
    HND_DBG_ENTER = 3'd3,
    HND_DBG_REDIR = 3'd4
  } handler_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam int unsigned BKPT_CODE      = 3;
  localparam logic [2:0]  DBG_CAUSE_SWBP = 3'd1;
endpackage

// File: rtl/trap_router.sv
module trap_router
  import trap_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 6
) (
  input  logic              irq,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        priv,
  input  logic              virt,
  input  logic              dbg,
  input  logic              en_m,
  input  logic              en_s,
  input  logic              en_u,
  input  logic [XLEN-1:0]   medeleg,
  input  logic [XLEN-1:0]   mideleg,
  input  logic [XLEN-1:0]   hedeleg,
  input  logic [XLEN-1:0]   hideleg,
  output handler_e          hnd,
  output logic              is_bkpt
);
  localparam int IDX_W = $clog2(XLEN);

  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic             low_priv;
  logic             ebk_hit;
  logic [XLEN-1:0]  vs_mask;
  logic [XLEN-1:0]  hs_mask;
  logic             vs_hit;
  logic             hs_hit;

  assign in_range = ((code >> IDX_W) == '0);
  assign idx      = code[IDX_W-1:0];
  assign low_priv = (priv <= PRIV_S);
  assign is_bkpt  = !irq && (code == CODE_W'(BKPT_CODE));

  always_comb begin
    unique case (priv)
      PRIV_M:  ebk_hit = en_m;
      PRIV_S:  ebk_hit = en_s;
      PRIV_U:  ebk_hit = en_u;
      default: ebk_hit = 1'b0;
    endcase
  end

  always_comb begin
    vs_mask = '0;
    hs_mask = '0;
    if (low_priv) begin
      hs_mask = irq ? mideleg : medeleg;
      if (virt) vs_mask = irq ? hideleg : (medeleg & hedeleg);
    end
  end

  assign vs_hit = in_range && vs_mask[idx];
  assign hs_hit = in_range && hs_mask[idx];

  always_comb begin
    if (dbg)                    hnd = HND_DBG_REDIR;
    else if (is_bkpt && ebk_hit) hnd = HND_DBG_ENTER;
    else if (vs_hit)            hnd = HND_VS;
    else if (hs_hit)            hnd = HND_HS;
    else                        hnd = HND_M;
  end
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_entry_pkg::*;
#(
  parameter int              XLEN          = 32,
  parameter int              CODE_W        = 6,
  parameter logic [XLEN-1:0] DBG_ROM_ENTRY = 32'h0000_0800,
  parameter logic [XLEN-1:0] DBG_EXC_VEC   = 32'h0000_0808
) (
  input  handler_e          hnd,
  input  logic              irq,
  input  logic [CODE_W-1:0] code,
  input  logic              is_bkpt,
  input  logic [XLEN-1:0]   mtvec,
  input  logic [XLEN-1:0]   stvec,
  input  logic [XLEN-1:0]   vstvec,
  output logic [XLEN-1:0]   next_pc
);
  localparam int NUM_LVL = 3;

  logic [XLEN-1:0] bases  [NUM_LVL];
  logic [XLEN-1:0] vec_pc [NUM_LVL];
  logic [XLEN-1:0] offset;

  assign bases[0] = mtvec;
  assign bases[1] = stvec;
  assign bases[2] = vstvec;
  assign offset   = XLEN'(code) << 2;

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign vec_pc[g] = {bases[g][XLEN-1:1], 1'b0} +
                       ((bases[g][0] && irq) ? offset : '0);
  end

  always_comb begin
    unique case (hnd)
      HND_DBG_REDIR: next_pc = is_bkpt ? DBG_ROM_ENTRY : DBG_EXC_VEC;
      HND_DBG_ENTER: next_pc = DBG_ROM_ENTRY;
      HND_VS:        next_pc = vec_pc[2];
      HND_HS:        next_pc = vec_pc[1];
      default:       next_pc = vec_pc[0];
    endcase
  end
endmodule

// File: rtl/trap_commit.sv
module trap_commit
  import trap_entry_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trap_valid,
  input  handler_e        hnd,
  input  logic [XLEN-1:0] next_pc,
  input  logic [XLEN-1:0] cause_full,
  input  logic [XLEN-1:0] cause_vs,
  input  logic [XLEN-1:0] epc,
  input  logic [XLEN-1:0] tval,
  input  logic            gva,
  input  logic [1:0]      priv,
  input  logic            virt,
  input  logic            cur_mie,
  input  logic            cur_sie,
  input  logic            cur_vsie,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output handler_e        handler_q,
  output logic [1:0]      new_priv,
  output logic            new_virt,
  output logic            debug_mode,
  output logic [XLEN-1:0] m_cause,
  output logic [XLEN-1:0] m_epc,
  output logic [XLEN-1:0] m_tval,
  output logic            m_ie,
  output logic            m_pie,
  output logic [1:0]      m_pp,
  output logic            m_pv,
  output logic            m_gva,
  output logic [XLEN-1:0] s_cause,
  output logic [XLEN-1:0] s_epc,
  output logic [XLEN-1:0] s_tval,
  output logic            s_ie,
  output logic            s_pie,
  output logic            s_pp,
  output logic            h_spv,
  output logic            h_spvp,
  output logic            h_gva,
  output logic [XLEN-1:0] vs_cause,
  output logic [XLEN-1:0] vs_epc,
  output logic [XLEN-1:0] vs_tval,
  output logic            vs_ie,
  output logic            vs_pie,
  output logic            vs_pp,
  output logic [2:0]      dbg_cause,
  output logic [1:0]      dbg_prv,
  output logic [XLEN-1:0] dbg_pc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= RESET_PC;
      handler_q      <= HND_M;
      new_priv       <= PRIV_M;
      new_virt       <= 1'b0;
      debug_mode     <= 1'b0;
      m_cause  <= '0; m_epc  <= '0; m_tval  <= '0;
      m_ie <= 1'b0; m_pie <= 1'b0; m_pp <= PRIV_U; m_pv <= 1'b0; m_gva <= 1'b0;
      s_cause  <= '0; s_epc  <= '0; s_tval  <= '0;
      s_ie <= 1'b0; s_pie <= 1'b0; s_pp <= 1'b0;
      h_spv <= 1'b0; h_spvp <= 1'b0; h_gva <= 1'b0;
      vs_cause <= '0; vs_epc <= '0; vs_tval <= '0;
      vs_ie <= 1'b0; vs_pie <= 1'b0; vs_pp <= 1'b0;
      dbg_cause <= '0; dbg_prv <= PRIV_U; dbg_pc <= '0;
    end else begin
      redirect_valid <= trap_valid;
      if (trap_valid) begin
        handler_q   <= hnd;
        redirect_pc <= next_pc;
        unique case (hnd)
          HND_DBG_REDIR: begin
            debug_mode <= 1'b1;
            new_priv   <= priv;
            new_virt   <= virt;
          end
          HND_DBG_ENTER: begin
            debug_mode <= 1'b1;
            dbg_cause  <= DBG_CAUSE_SWBP;
            dbg_prv    <= priv;
            dbg_pc     <= epc;
            new_priv   <= PRIV_M;
            new_virt   <= virt;
          end
          HND_VS: begin
            debug_mode <= 1'b0;
            vs_cause   <= cause_vs;
            vs_epc     <= epc;
            vs_tval    <= tval;
            vs_pie     <= cur_vsie;
            vs_pp      <= priv[0];
            vs_ie      <= 1'b0;
            new_priv   <= PRIV_S;
            new_virt   <= 1'b1;
          end
          HND_HS: begin
            debug_mode <= 1'b0;
            s_cause    <= cause_full;
            s_epc      <= epc;
            s_tval     <= tval;
            s_pie      <= cur_sie;
            s_pp       <= priv[0];
            s_ie       <= 1'b0;
            h_spv      <= virt;
            h_gva      <= gva;
            if (virt) h_spvp <= priv[0];
            new_priv   <= PRIV_S;
            new_virt   <= 1'b0;
          end
          default: begin
            debug_mode <= 1'b0;
            m_cause    <= cause_full;
            m_epc      <= epc;
            m_tval     <= tval;
            m_pie      <= cur_mie;
            m_pp       <= priv;
            m_ie       <= 1'b0;
            m_pv       <= virt;
            m_gva      <= gva;
            new_priv   <= PRIV_M;
            new_virt   <= 1'b0;
          end
        endcase
      end
    end
  end

  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !trap_valid |=> (!redirect_valid && $stable(redirect_pc) && $stable(new_priv)
                     && $stable(m_cause) && $stable(s_cause) && $stable(vs_cause)));

  assert_redir_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && hnd == HND_DBG_REDIR) |=>
      (debug_mode && $stable(m_cause) && $stable(s_cause) && $stable(vs_cause)
       && $stable(dbg_pc)));

  assert_dbg_enter_R3: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && handler_q == HND_DBG_ENTER) |->
      (debug_mode && new_priv == PRIV_M && dbg_cause == DBG_CAUSE_SWBP));

  assert_vs_level_R4: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && handler_q == HND_VS) |-> (new_virt && new_priv == PRIV_S && !vs_ie));

  assert_hs_level_R5: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && handler_q == HND_HS) |-> (!new_virt && new_priv == PRIV_S && !s_ie));

  assert_m_level_R11: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && handler_q == HND_M) |-> (!new_virt && new_priv == PRIV_M && !m_ie));
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter int              XLEN          = 32,
  parameter int              CODE_W        = 6,
  parameter logic [XLEN-1:0] DBG_ROM_ENTRY = 32'h0000_0800,
  parameter logic [XLEN-1:0] DBG_EXC_VEC   = 32'h0000_0808,
  parameter logic [XLEN-1:0] RESET_PC      = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trap_valid,
  input  logic              trap_irq,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   trap_epc,
  input  logic [XLEN-1:0]   trap_tval,
  input  logic              trap_gva,
  input  logic [1:0]        cur_priv,
  input  logic              cur_virt,
  input  logic              cur_debug,
  input  logic              cur_mie,
  input  logic              cur_sie,
  input  logic              cur_vsie,
  input  logic              ebk_en_m,
  input  logic              ebk_en_s,
  input  logic              ebk_en_u,
  input  logic [XLEN-1:0]   medeleg,
  input  logic [XLEN-1:0]   mideleg,
  input  logic [XLEN-1:0]   hedeleg,
  input  logic [XLEN-1:0]   hideleg,
  input  logic [XLEN-1:0]   mtvec,
  input  logic [XLEN-1:0]   stvec,
  input  logic [XLEN-1:0]   vstvec,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [2:0]        handler,
  output logic [1:0]        new_priv,
  output logic              new_virt,
  output logic              debug_mode,
  output logic [XLEN-1:0]   m_cause,
  output logic [XLEN-1:0]   m_epc,
  output logic [XLEN-1:0]   m_tval,
  output logic              m_ie,
  output logic              m_pie,
  output logic [1:0]        m_pp,
  output logic              m_pv,
  output logic              m_gva,
  output logic [XLEN-1:0]   s_cause,
  output logic [XLEN-1:0]   s_epc,
  output logic [XLEN-1:0]   s_tval,
  output logic              s_ie,
  output logic              s_pie,
  output logic              s_pp,
  output logic              h_spv,
  output logic              h_spvp,
  output logic              h_gva,
  output logic [XLEN-1:0]   vs_cause,
  output logic [XLEN-1:0]   vs_epc,
  output logic [XLEN-1:0]   vs_tval,
  output logic              vs_ie,
  output logic              vs_pie,
  output logic              vs_pp,
  output logic [2:0]        dbg_cause,
  output logic [1:0]        dbg_prv,
  output logic [XLEN-1:0]   dbg_pc
);
  handler_e        hnd;
  handler_e        handler_q;
  logic            is_bkpt;
  logic [XLEN-1:0] next_pc;
  logic [XLEN-1:0] cause_full;
  logic [XLEN-1:0] cause_vs;

  assign cause_full = {trap_irq, {(XLEN-1-CODE_W){1'b0}}, trap_code};
  assign cause_vs   = trap_irq ? (cause_full - XLEN'(1)) : cause_full;
  assign handler    = handler_q;

  trap_router #(.XLEN(XLEN), .CODE_W(CODE_W)) u_router (
    .irq(trap_irq), .code(trap_code), .priv(cur_priv), .virt(cur_virt),
    .dbg(cur_debug), .en_m(ebk_en_m), .en_s(ebk_en_s), .en_u(ebk_en_u),
    .medeleg(medeleg), .mideleg(mideleg), .hedeleg(hedeleg), .hideleg(hideleg),
    .hnd(hnd), .is_bkpt(is_bkpt)
  );

  trap_target #(.XLEN(XLEN), .CODE_W(CODE_W),
                .DBG_ROM_ENTRY(DBG_ROM_ENTRY), .DBG_EXC_VEC(DBG_EXC_VEC)) u_target (
    .hnd(hnd), .irq(trap_irq), .code(trap_code), .is_bkpt(is_bkpt),
    .mtvec(mtvec), .stvec(stvec), .vstvec(vstvec), .next_pc(next_pc)
  );

  trap_commit #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_commit (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .hnd(hnd), .next_pc(next_pc),
    .cause_full(cause_full), .cause_vs(cause_vs), .epc(trap_epc), .tval(trap_tval),
    .gva(trap_gva), .priv(cur_priv), .virt(cur_virt), .cur_mie(cur_mie),
    .cur_sie(cur_sie), .cur_vsie(cur_vsie),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .handler_q(handler_q),
    .new_priv(new_priv), .new_virt(new_virt), .debug_mode(debug_mode),
    .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval), .m_ie(m_ie), .m_pie(m_pie),
    .m_pp(m_pp), .m_pv(m_pv), .m_gva(m_gva),
    .s_cause(s_cause), .s_epc(s_epc), .s_tval(s_tval), .s_ie(s_ie), .s_pie(s_pie),
    .s_pp(s_pp), .h_spv(h_spv), .h_spvp(h_spvp), .h_gva(h_gva),
    .vs_cause(vs_cause), .vs_epc(vs_epc), .vs_tval(vs_tval), .vs_ie(vs_ie),
    .vs_pie(vs_pie), .vs_pp(vs_pp),
    .dbg_cause(dbg_cause), .dbg_prv(dbg_prv), .dbg_pc(dbg_pc)
  );

  assert_machine_fallback_R6: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && cur_priv == PRIV_M && !cur_debug) |=>
      (handler_q == HND_M || handler_q == HND_DBG_ENTER));

  assert_wide_code_R6: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && !cur_debug && (int'(trap_code) >= XLEN)) |=> (handler_q == HND_M));
endmodule

// File: tb/tb_trap_entry_unit.sv
module tb_trap_entry_unit;
  localparam int XLEN = 32;
  localparam int CODE_W = 6;
  localparam logic [31:0] ROM = 32'h0000_0800;
  localparam logic [31:0] EXC = 32'h0000_0808;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trap_valid = 0, trap_irq = 0, trap_gva = 0;
  logic [CODE_W-1:0] trap_code = '0;
  logic [31:0] trap_epc = '0, trap_tval = '0;
  logic [1:0] cur_priv = 2'd3;
  logic cur_virt = 0, cur_debug = 0, cur_mie = 0, cur_sie = 0, cur_vsie = 0;
  logic ebk_en_m = 0, ebk_en_s = 0, ebk_en_u = 0;
  logic [31:0] medeleg = '0, mideleg = '0, hedeleg = '0, hideleg = '0;
  logic [31:0] mtvec = '0, stvec = '0, vstvec = '0;

  logic redirect_valid, new_virt, debug_mode;
  logic [31:0] redirect_pc;
  logic [2:0] handler, dbg_cause;
  logic [1:0] new_priv, m_pp, dbg_prv;
  logic [31:0] m_cause, m_epc, m_tval, s_cause, s_epc, s_tval, vs_cause, vs_epc, vs_tval, dbg_pc;
  logic m_ie, m_pie, m_pv, m_gva, s_ie, s_pie, s_pp, h_spv, h_spvp, h_gva, vs_ie, vs_pie, vs_pp;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  trap_entry_unit dut (
    .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_irq(trap_irq),
    .trap_code(trap_code), .trap_epc(trap_epc), .trap_tval(trap_tval), .trap_gva(trap_gva),
    .cur_priv(cur_priv), .cur_virt(cur_virt), .cur_debug(cur_debug), .cur_mie(cur_mie),
    .cur_sie(cur_sie), .cur_vsie(cur_vsie), .ebk_en_m(ebk_en_m), .ebk_en_s(ebk_en_s),
    .ebk_en_u(ebk_en_u), .medeleg(medeleg), .mideleg(mideleg), .hedeleg(hedeleg),
    .hideleg(hideleg), .mtvec(mtvec), .stvec(stvec), .vstvec(vstvec),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .handler(handler),
    .new_priv(new_priv), .new_virt(new_virt), .debug_mode(debug_mode),
    .m_cause(m_cause), .m_epc(m_epc), .m_tval(m_tval), .m_ie(m_ie), .m_pie(m_pie),
    .m_pp(m_pp), .m_pv(m_pv), .m_gva(m_gva), .s_cause(s_cause), .s_epc(s_epc),
    .s_tval(s_tval), .s_ie(s_ie), .s_pie(s_pie), .s_pp(s_pp), .h_spv(h_spv),
    .h_spvp(h_spvp), .h_gva(h_gva), .vs_cause(vs_cause), .vs_epc(vs_epc),
    .vs_tval(vs_tval), .vs_ie(vs_ie), .vs_pie(vs_pie), .vs_pp(vs_pp),
    .dbg_cause(dbg_cause), .dbg_prv(dbg_prv), .dbg_pc(dbg_pc)
  );

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk) trap_valid = 1'b1;
    @(posedge clk);
    @(negedge clk) trap_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "priv", new_priv, 3);
    chk("R1", "virt", new_virt, 0);
    chk("R1", "debug", debug_mode, 0);
    chk("R1", "valid", redirect_valid, 0);
    chk("R1", "m_cause", m_cause, 0);
    chk("R1", "s_epc", s_epc, 0);
    chk("R1", "vs_tval", vs_tval, 0);
  endtask

  task automatic t_machine_exc();
    cur_priv = 3; cur_virt = 0; medeleg = '1; mideleg = '0;
    mtvec = 32'h8000_0101; trap_irq = 0; trap_code = 2;
    trap_epc = 32'h100; trap_tval = 32'hDEAD; trap_gva = 1; cur_mie = 1;
    fire();
    chk("R6", "handler", handler, 0);
    chk("R7", "pc", redirect_pc, 32'h8000_0100);
    chk("R8", "m_cause", m_cause, 2);
    chk("R11", "m_epc", m_epc, 32'h100);
    chk("R11", "m_tval", m_tval, 32'hDEAD);
    chk("R11", "m_pie", m_pie, 1);
    chk("R11", "m_ie", m_ie, 0);
    chk("R11", "m_pp", m_pp, 3);
    chk("R11", "m_pv", m_pv, 0);
    chk("R11", "m_gva", m_gva, 1);
    chk("R12", "valid", redirect_valid, 1);
    trap_code = 5; trap_epc = 32'h999;
    @(negedge clk);
    chk("R12", "valid low", redirect_valid, 0);
    @(negedge clk);
    chk("R12", "hold cause", m_cause, 2);
    chk("R12", "hold epc", m_epc, 32'h100);
  endtask

  task automatic t_machine_irq();
    cur_priv = 0; cur_virt = 1; medeleg = '0; mideleg = '0; hideleg = '0;
    trap_irq = 1; trap_code = 7; mtvec = 32'h8000_0001; cur_mie = 0; trap_gva = 0;
    fire();
    chk("R6", "handler", handler, 0);
    chk("R7", "pc", redirect_pc, 32'h8000_001C);
    chk("R8", "m_cause", m_cause, 32'h8000_0007);
    chk("R11", "m_pp", m_pp, 0);
    chk("R11", "m_pv", m_pv, 1);
    chk("R11", "m_pie", m_pie, 0);
    chk("R6", "virt", new_virt, 0);
    chk("R6", "priv", new_priv, 3);
  endtask

  task automatic t_hs_irq_from_guest();
    cur_priv = 1; cur_virt = 1; mideleg = 32'h1 << 9; hideleg = '0;
    trap_irq = 1; trap_code = 9; stvec = 32'h4000_0001; cur_sie = 1; trap_gva = 1;
    fire();
    chk("R5", "handler", handler, 1);
    chk("R7", "pc", redirect_pc, 32'h4000_0024);
    chk("R8", "s_cause", s_cause, 32'h8000_0009);
    chk("R9", "s_pie", s_pie, 1);
    chk("R9", "s_ie", s_ie, 0);
    chk("R9", "s_pp", s_pp, 1);
    chk("R10", "h_spv", h_spv, 1);
    chk("R10", "h_spvp", h_spvp, 1);
    chk("R10", "h_gva", h_gva, 1);
    chk("R5", "priv", new_priv, 1);
    chk("R5", "virt", new_virt, 0);
  endtask

  task automatic t_hs_exc_native();
    cur_priv = 1; cur_virt = 0; medeleg = 32'h1 << 13; mideleg = '0;
    trap_irq = 0; trap_code = 13; cur_sie = 0; trap_gva = 0;
    trap_epc = 32'h200; trap_tval = 32'h55;
    fire();
    chk("R5", "handler", handler, 1);
    chk("R7", "pc no offset", redirect_pc, 32'h4000_0000);
    chk("R8", "s_cause", s_cause, 13);
    chk("R5", "s_epc", s_epc, 32'h200);
    chk("R5", "s_tval", s_tval, 32'h55);
    chk("R9", "s_pie", s_pie, 0);
    chk("R10", "h_spv", h_spv, 0);
    chk("R10", "h_spvp kept", h_spvp, 1);
    chk("R10", "h_gva", h_gva, 0);
  endtask

  task automatic t_vs_irq();
    cur_priv = 0; cur_virt = 1; mideleg = 32'h1 << 10; hideleg = 32'h1 << 10;
    trap_irq = 1; trap_code = 10; vstvec = 32'h2000_0001; cur_vsie = 1; cur_sie = 0;
    fire();
    chk("R4", "handler", handler, 2);
    chk("R7", "pc", redirect_pc, 32'h2000_0028);
    chk("R8", "vs_cause minus one", vs_cause, 32'h8000_0009);
    chk("R9", "vs_pie", vs_pie, 1);
    chk("R9", "vs_ie", vs_ie, 0);
    chk("R9", "vs_pp", vs_pp, 0);
    chk("R4", "priv", new_priv, 1);
    chk("R4", "virt", new_virt, 1);
    chk("R4", "s_cause untouched", s_cause, 13);
  endtask

  task automatic t_vs_exc_masks();
    cur_priv = 0; cur_virt = 1; trap_irq = 0; trap_code = 8;
    mideleg = '0; hideleg = '0; medeleg = '0; hedeleg = 32'h1 << 8;
    fire();
    chk("R6", "hedeleg alone -> M", handler, 0);
    chk("R6", "m_cause", m_cause, 8);
    medeleg = 32'h1 << 8;
    fire();
    chk("R4", "both masks -> VS", handler, 2);
    chk("R8", "vs exc cause", vs_cause, 8);
    chk("R7", "vs exc pc", redirect_pc, 32'h2000_0000);
    hedeleg = '0;
    fire();
    chk("R5", "medeleg alone -> HS", handler, 1);
  endtask

  task automatic t_wide_code();
    cur_priv = 0; cur_virt = 1; medeleg = '1; mideleg = '1; hedeleg = '1; hideleg = '1;
    trap_irq = 1; trap_code = 40; mtvec = 32'h8000_0001;
    fire();
    chk("R6", "code>=XLEN handler", handler, 0);
    chk("R7", "pc", redirect_pc, 32'h8000_00A0);
    chk("R8", "m_cause", m_cause, 32'h8000_0028);
  endtask

  task automatic t_debug_entry();
    cur_priv = 1; cur_virt = 0; ebk_en_s = 1; trap_irq = 0; trap_code = 3;
    trap_epc = 32'h1234; medeleg = '1;
    fire();
    chk("R3", "handler", handler, 3);
    chk("R3", "pc", redirect_pc, ROM);
    chk("R3", "debug", debug_mode, 1);
    chk("R3", "priv", new_priv, 3);
    chk("R3", "dbg_cause", dbg_cause, 1);
    chk("R3", "dbg_prv", dbg_prv, 1);
    chk("R3", "dbg_pc", dbg_pc, 32'h1234);
    chk("R3", "m_cause untouched", m_cause, 32'h8000_0028);
  endtask

  task automatic t_bkpt_no_enable();
    cur_priv = 0; ebk_en_u = 0; ebk_en_s = 1; ebk_en_m = 1; medeleg = '0;
    mideleg = '0; cur_virt = 0; trap_code = 3; trap_irq = 0; mtvec = 32'h8000_0001;
    fire();
    chk("R3", "no enable -> M", handler, 0);
    chk("R7", "pc", redirect_pc, 32'h8000_0000);
    chk("R8", "m_cause", m_cause, 3);
    chk("R3", "debug off", debug_mode, 0);
  endtask

  task automatic t_debug_redirect();
    cur_debug = 1; cur_priv = 3; ebk_en_m = 1; trap_irq = 0; trap_code = 3;
    trap_epc = 32'h7777;
    fire();
    chk("R2", "handler", handler, 4);
    chk("R2", "bkpt pc", redirect_pc, ROM);
    chk("R2", "priv", new_priv, 3);
    chk("R2", "debug", debug_mode, 1);
    chk("R2", "m_cause kept", m_cause, 3);
    chk("R2", "dbg_pc kept", dbg_pc, 32'h1234);
    trap_irq = 1;
    fire();
    chk("R2", "irq code 3 pc", redirect_pc, EXC);
    trap_irq = 0; trap_code = 2; cur_priv = 1; cur_virt = 1;
    fire();
    chk("R2", "other exc pc", redirect_pc, EXC);
    chk("R2", "priv kept", new_priv, 1);
    chk("R2", "virt kept", new_virt, 1);
    chk("R2", "vs_cause kept", vs_cause, 8);
    cur_debug = 0;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_machine_exc();
    t_machine_irq();
    t_hs_irq_from_guest();
    t_hs_exc_native();
    t_vs_irq();
    t_vs_exc_masks();
    t_wide_code();
    t_debug_entry();
    t_bkpt_no_enable();
    t_debug_redirect();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule